// File: doc/BRIEF.md
# I2C SCL Clock and Data-Slot Timing Generator

This block produces the serial clock of an I2C bus controller and tells the byte engine when it may change the data line and when a received bit can be sampled. All timing is derived from one kernel clock. A shared prescaler divides that clock into time-base ticks. The low and high halves of the clock are counted separately, in ticks, so an asymmetric clock is easy to set up, for example a low half twice as long as the high half. Two small delay fields control the data line. One places the data-change slot a set number of ticks after the clock falls. The other guarantees a minimum number of ticks between that slot and the release of the clock.

The block drives the clock as an open-drain pull-down. It watches the real bus line through a synchroniser and starts counting the high half only once the line is seen high. A device that stretches the clock by holding the line low therefore lengthens the low half instead of shortening the high half. The byte engine asserts `run` for as long as it wants clock pulses. `run` is examined at the end of every high half. The timing word is taken only while no transfer is in progress.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `rst` is high, and afterwards until a transfer starts, `scl_pull_low`, `sda_slot` and `scl_rise` are all 0, so the clock line is released.
- R2: `cfg_word` holds five fields: bits [3:0] are the prescale value P, bits [11:4] the low count L, bits [19:12] the high count H, bits [23:20] the hold delay D, and bits [27:24] the setup delay S. The word is sampled in every idle cycle, including the cycle in which a transfer starts. Changes made after that take effect only at the next start from idle.
- R3: Each low half holds `scl_pull_low` at 1 for exactly max(L+1, D+S+1)·(P+1) consecutive cycles.
- R4: In each low half, `sda_slot` pulses exactly once, D·(P+1) cycles after the first low cycle. When D = 0 it pulses in the first low cycle itself.
- R5: After the line is first seen high, `scl_rise` pulses SYNC_STAGES+1 cycles later. `scl_pull_low` returns to 1 exactly (H+1)·(P+1) cycles after the `scl_rise` cycle, where the `scl_rise` cycle is counted as the first.
- R6: If another device holds the line low after release, `scl_rise` is delayed by the number of cycles the line is held low. The length of the following high half stays (H+1)·(P+1) cycles.
- R7: From idle, `run` = 1 with `en` = 1 makes `scl_pull_low` go to 1 in the next cycle. At the end of each high half, `run` = 1 starts a new low half in the next cycle. `run` = 0 at that point leaves the line released, with no strobes, until a new start.
- R8: `en` = 0 returns the block to idle. In the next cycle all three outputs are 0, and `run` has no effect while `en` stays 0.
- R9: `sda_slot` and `scl_rise` are single-cycle pulses and never occur together. `sda_slot` occurs only while the clock is pulled low. `scl_rise` occurs only while the clock is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; low forces idle |
| run | input | 1 | Byte engine requests further clock pulses |
| cfg_word | input | CFG_W (28) | Packed timing word: P, L, H, D, S (see R2) |
| scl_line_in | input | 1 | Sensed level of the bus clock line (asynchronous) |
| scl_pull_low | output | 1 | 1 = drive the clock line low (open drain) |
| sda_slot | output | 1 | One-cycle strobe: the data line may change now |
| scl_rise | output | 1 | One-cycle strobe: the clock has risen; sample received data |

## Verification
A wrong tick or phase counter shows up at the ports within one bit period. The low half or high half comes out a whole number of prescaled ticks too long or too short, and the edge of `scl_pull_low` moves on the very cycle the count ends. A fault in the synchroniser or the edge detector shifts `scl_rise` in the first released cycles, or causes it to be missed so that the clock stays high. A reference model compares the bench against every output on every cycle, so any such slip is caught on the cycle it occurs. Configuration capture is checked by changing the timing word in the middle of a transfer and watching whether the low half changes length before the next start.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;

  // Phase of the generated serial clock
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // line released, waiting for a start request
    PH_LOW  = 2'd1,  // clock pulled low, data slot and setup counting
    PH_WAIT = 2'd2,  // clock released, waiting for the line to read high
    PH_HIGH = 2'd3   // clock high, counting the high half
  } phase_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2ct_prescaler.sv
`timescale 1ns/1ps
// Shared time base: one tick every (presc+1) kernel cycles, restarted by hold.
module i2ct_prescaler #(
  parameter int unsigned PRESC_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);

  logic [PRESC_W-1:0] cnt_q;
  logic               wrap;

  assign wrap = (cnt_q == presc);
  assign tick = wrap && !hold;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/i2ct_scl_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for the sensed clock line with a rising-edge detect.
module i2ct_scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic rise
);

  // Stages 0..STAGES-1 form the synchroniser; stage STAGES is the delayed copy
  logic [STAGES:0] sh_q;

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b1;
          else     sh_q[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b1;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];

endmodule

// File: rtl/i2ct_phase_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: low half, wait-for-line, high half, with registered strobes.
module i2ct_phase_ctrl
  import i2ct_pkg::*;
#(
  parameter int unsigned DEL_W = 4,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             tick,
  input  logic             line_rise,
  input  logic [DEL_W-1:0] hold_d,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  output phase_e           phase,
  output logic             scl_low,
  output logic             sda_pulse,
  output logic             rise_pulse
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e           phase_q;
  logic [CNT_W-1:0] tcnt_q;
  logic [CNT_W-1:0] tnext;
  logic [CNT_W-1:0] hold_ext;
  logic             hold_zero;

  assign tnext     = tcnt_q + ONE;
  assign hold_ext  = CNT_W'(hold_d);
  assign hold_zero = (hold_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      tcnt_q     <= '0;
      scl_low    <= 1'b0;
      sda_pulse  <= 1'b0;
      rise_pulse <= 1'b0;
    end else begin
      sda_pulse  <= 1'b0;
      rise_pulse <= 1'b0;
      if (!en) begin
        phase_q <= PH_IDLE;
        tcnt_q  <= '0;
        scl_low <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_IDLE: begin
            if (run) begin
              phase_q   <= PH_LOW;
              tcnt_q    <= '0;
              scl_low   <= 1'b1;
              sda_pulse <= hold_zero;
            end
          end
          PH_LOW: begin
            if (tick) begin
              tcnt_q <= tnext;
              if (!hold_zero && (tnext == hold_ext)) begin
                sda_pulse <= 1'b1;
              end
              if (tnext == low_len) begin
                tcnt_q  <= '0;
                scl_low <= 1'b0;
                phase_q <= PH_WAIT;
              end
            end
          end
          PH_WAIT: begin
            if (line_rise) begin
              phase_q    <= PH_HIGH;
              tcnt_q     <= '0;
              rise_pulse <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (tick) begin
              tcnt_q <= tnext;
              if (tnext == high_len) begin
                tcnt_q <= '0;
                if (run) begin
                  phase_q   <= PH_LOW;
                  scl_low   <= 1'b1;
                  sda_pulse <= hold_zero;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
// Top: configuration capture, length derivation, and the three sub-blocks.
module i2c_scl_timer
  import i2ct_pkg::*;
#(
  parameter int unsigned PRESC_W     = 4,
  parameter int unsigned LOW_W       = 8,
  parameter int unsigned HIGH_W      = 8,
  parameter int unsigned DEL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CFG_W      = PRESC_W + LOW_W + HIGH_W + 2 * DEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             scl_line_in,
  output logic             scl_pull_low,
  output logic             sda_slot,
  output logic             scl_rise
);

  localparam int unsigned CNT_W   = umax(umax(LOW_W, HIGH_W), DEL_W + 1) + 1;
  localparam int unsigned OFS_LOW = PRESC_W;
  localparam int unsigned OFS_HI  = OFS_LOW + LOW_W;
  localparam int unsigned OFS_HLD = OFS_HI + HIGH_W;
  localparam int unsigned OFS_SET = OFS_HLD + DEL_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e             phase;
  logic [CFG_W-1:0]   cap_q;
  logic [CFG_W-1:0]   eff;
  logic [PRESC_W-1:0] f_presc;
  logic [LOW_W-1:0]   f_low;
  logic [HIGH_W-1:0]  f_high;
  logic [DEL_W-1:0]   f_hold;
  logic [DEL_W-1:0]   f_setup;
  logic [CNT_W-1:0]   len_low_cnt;
  logic [CNT_W-1:0]   len_del_sum;
  logic [CNT_W-1:0]   low_len;
  logic [CNT_W-1:0]   high_len;
  logic               tick;
  logic               pre_hold;
  logic               line_rise;

  // Timing word follows the input while idle and is frozen during a transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (phase == PH_IDLE) begin
      cap_q <= cfg_word;
    end
  end

  assign eff     = (phase == PH_IDLE) ? cfg_word : cap_q;
  assign f_presc = eff[PRESC_W-1:0];
  assign f_low   = eff[OFS_LOW +: LOW_W];
  assign f_high  = eff[OFS_HI  +: HIGH_W];
  assign f_hold  = eff[OFS_HLD +: DEL_W];
  assign f_setup = eff[OFS_SET +: DEL_W];

  // Low half must cover both the low count and the hold-plus-setup window
  always_comb begin
    len_low_cnt = CNT_W'(f_low) + ONE;
    len_del_sum = CNT_W'(f_hold) + CNT_W'(f_setup) + ONE;
    low_len     = (len_low_cnt > len_del_sum) ? len_low_cnt : len_del_sum;
    high_len    = CNT_W'(f_high) + ONE;
  end

  assign pre_hold = !en || (phase == PH_IDLE) || (phase == PH_WAIT);

  i2ct_prescaler #(
    .PRESC_W (PRESC_W)
  ) u_presc (
    .clk   (clk),
    .rst   (rst),
    .hold  (pre_hold),
    .presc (f_presc),
    .tick  (tick)
  );

  i2ct_scl_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_in (scl_line_in),
    .rise    (line_rise)
  );

  i2ct_phase_ctrl #(
    .DEL_W (DEL_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .run        (run),
    .tick       (tick),
    .line_rise  (line_rise),
    .hold_d     (f_hold),
    .low_len    (low_len),
    .high_len   (high_len),
    .phase      (phase),
    .scl_low    (scl_pull_low),
    .sda_pulse  (sda_slot),
    .rise_pulse (scl_rise)
  );

endmodule

// File: rtl/i2ct_timing_chk.sv
`timescale 1ns/1ps
module i2ct_timing_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic run,
  input logic scl_pull_low,
  input logic sda_slot,
  input logic scl_rise
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sda_slot && scl_rise)); // R9

  AST_SDA_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sda_slot |=> !sda_slot); // R9

  AST_SDA_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    sda_slot |-> scl_pull_low); // R4

  AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    scl_rise |-> !scl_pull_low); // R5

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_pull_low && !sda_slot && !scl_rise)); // R8

  AST_PULL_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull_low) |-> $past(run && en)); // R7

endmodule

bind i2c_scl_timer i2ct_timing_chk u_timing_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .run          (run),
  .scl_pull_low (scl_pull_low),
  .sda_slot     (sda_slot),
  .scl_rise     (scl_rise)
);

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;

  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst, en, run;
  logic [27:0] cfg_w;
  logic        scl_line, pull_low, sda_slot, scl_rise;
  logic        hold_low = 1'b0;

  int compared = 0, mismatched = 0, cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk; // 50 MHz

  assign scl_line = !pull_low && !hold_low;

  i2c_scl_timer i_i2c_scl_timer (
    .clk (clk), .rst (rst), .en (en), .run (run), .cfg_word (cfg_w),
    .scl_line_in (scl_line), .scl_pull_low (pull_low),
    .sda_slot (sda_slot), .scl_rise (scl_rise)
  );

  function automatic logic [27:0] mk(int p, int l, int h, int d, int s);
    return {4'(s), 4'(d), 8'(h), 8'(l), 4'(p)};
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_st = 0, m_ph = 0, mP = 0, mL = 1, mH = 1, mD = 0;
  logic exp_low = 0, exp_sda = 0, exp_rise = 0;
  logic line_smp = 1'b1;
  logic hist [0:7];
  bit   cmp_on = 0;

  initial for (int k = 0; k < 8; k++) hist[k] = 1'b1;

  always @(posedge clk) begin
    logic rise_cond;
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = line_smp;
    exp_sda = 1'b0;
    exp_rise = 1'b0;
    if (rst) begin
      m_st = 0; exp_low = 1'b0;
      for (int k = 0; k < 8; k++) hist[k] = 1'b1;
    end else if (!en) begin
      m_st = 0; exp_low = 1'b0;
    end else begin
      rise_cond = hist[SYNC] && !hist[SYNC+1];
      case (m_st)
        0: if (run) begin
          mP = int'(cfg_w[3:0]); mH = int'(cfg_w[19:12]) + 1;
          mD = int'(cfg_w[23:20]);
          mL = imax(int'(cfg_w[11:4]) + 1, mD + int'(cfg_w[27:24]) + 1);
          m_st = 1; m_ph = 0; exp_low = 1'b1; exp_sda = (mD == 0);
        end
        1: begin
          m_ph++;
          if (mD != 0 && m_ph == mD * (mP + 1)) exp_sda = 1'b1;
          if (m_ph == mL * (mP + 1)) begin exp_low = 1'b0; m_st = 2; end
        end
        2: if (rise_cond) begin m_st = 3; m_ph = 0; exp_rise = 1'b1; end
        default: begin
          m_ph++;
          if (m_ph == mH * (mP + 1)) begin
            if (run) begin
              m_st = 1; m_ph = 0; exp_low = 1'b1; exp_sda = (mD == 0);
            end else m_st = 0;
          end
        end
      endcase
    end
  end

  // ---------------- per-cycle compare, measurement, bus stretching ----------------
  int   meas_low = -1, meas_sda = -1, meas_sdan = -1, meas_high = -1, meas_rel = -1;
  int   lcnt = 0, scnt = 0, hcnt = 0, rcnt = 0, stretch_n = 0, left = 0;
  bit   harm = 0, rarm = 0;
  logic prev_pull = 1'b0;

  always @(negedge clk) begin
    logic fall;
    if (cmp_on) begin
      compared++;
      if ({pull_low, sda_slot, scl_rise} !== {exp_low, exp_sda, exp_rise}) begin
        mismatched++;
        $display("FAIL %s per-cycle actual=%b%b%b expected=%b%b%b at cycle %0d",
                 cur_req, pull_low, sda_slot, scl_rise, exp_low, exp_sda, exp_rise, cyc);
      end
    end
    fall = prev_pull && !pull_low;
    if (pull_low) begin
      if (sda_slot) begin meas_sda = lcnt; scnt++; end
      lcnt++;
    end else if (fall) begin
      meas_low = lcnt; meas_sdan = scnt; lcnt = 0; scnt = 0;
    end
    if (scl_rise) begin hcnt = 1; harm = 1; end
    else if (harm) begin
      if (pull_low) begin meas_high = hcnt; harm = 0; end
      else hcnt++;
    end
    if (fall) begin rcnt = 1; rarm = 1; end
    else if (rarm) begin
      if (scl_rise) begin meas_rel = rcnt; rarm = 0; end
      else rcnt++;
    end
    if (fall) left = stretch_n;
    else if (left > 0) left--;
    hold_low = (left > 0);
    line_smp = !pull_low && !hold_low;
    prev_pull = pull_low;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic xfer(int p, int l, int h, int d, int s, int nbits, int strn);
    @(negedge clk);
    cfg_w = mk(p, l, h, d, s); stretch_n = strn; run = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      do @(negedge clk); while (!scl_rise);
    end
    run = 1'b0;
    repeat ((h + 1) * (p + 1) + 10) @(negedge clk);
  endtask

  initial begin
    int cnt;
    rst = 1'b1; en = 1'b0; run = 1'b0; cfg_w = '0;
    repeat (4) @(negedge clk);
    chk("R1 pull during reset", int'(pull_low), 0);
    chk("R1 strobes during reset", int'(sda_slot | scl_rise), 0);
    rst = 1'b0; en = 1'b1; cmp_on = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", int'(pull_low), 0);

    cur_req = "R3/R4/R5 config A";
    xfer(0, 4, 2, 1, 1, 3, 0);
    chk("R3 low length A", meas_low, 5);
    chk("R4 slot offset A", meas_sda, 1);
    chk("R4 one slot per low A", meas_sdan, 1);
    chk("R5 high length A", meas_high, 3);
    chk("R5 rise latency A", meas_rel, SYNC + 1);

    cur_req = "R3/R4 setup-dominated B";
    xfer(3, 1, 1, 3, 4, 2, 0);
    chk("R3 low length B", meas_low, 32);
    chk("R4 slot offset B", meas_sda, 12);
    chk("R9 single slot B", meas_sdan, 1);
    chk("R5 high length B", meas_high, 8);

    cur_req = "R4 zero hold C";
    xfer(1, 9, 4, 0, 2, 2, 0);
    chk("R3 low length C", meas_low, 20);
    chk("R4 slot at first low cycle", meas_sda, 0);
    chk("R5 high length C", meas_high, 10);

    cur_req = "R3 all-zero config";
    xfer(0, 0, 0, 0, 0, 3, 0);
    chk("R3 low length min", meas_low, 1);
    chk("R4 slot min", meas_sda, 0);
    chk("R5 high length min", meas_high, 1);
    chk("R5 rise latency min", meas_rel, SYNC + 1);

    cur_req = "R6 stretching";
    xfer(0, 4, 2, 1, 1, 3, 7);
    chk("R6 stretched rise latency", meas_rel, 7 + SYNC + 1);
    chk("R6 high length unchanged", meas_high, 3);
    chk("R6 low length unchanged", meas_low, 5);
    stretch_n = 0;

    cur_req = "R2 mid-transfer config change";
    @(negedge clk);
    cfg_w = mk(0, 4, 2, 1, 1); run = 1'b1;
    do @(negedge clk); while (!scl_rise);
    cfg_w = mk(3, 1, 1, 3, 4);
    for (int i = 0; i < 3; i++) begin
      do @(negedge clk); while (!scl_rise);
    end
    run = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 low length kept", meas_low, 5);
    chk("R2 high length kept", meas_high, 3);
    xfer(3, 1, 1, 3, 4, 2, 0);
    chk("R2 new word at next start", meas_low, 32);

    cur_req = "R7 run control";
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pull_low || sda_slot || scl_rise) cnt++;
    end
    chk("R7 released while run low", cnt, 0);
    run = 1'b1;
    @(negedge clk);
    chk("R7 start latency", int'(pull_low), 1);
    do @(negedge clk); while (!scl_rise);
    run = 1'b0;
    repeat (20) @(negedge clk);

    cur_req = "R8 disable";
    run = 1'b1;
    do @(negedge clk); while (!pull_low);
    en = 1'b0;
    @(negedge clk);
    chk("R8 released after disable", int'(pull_low), 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pull_low || sda_slot || scl_rise) cnt++;
    end
    chk("R8 run ignored while disabled", cnt, 0);
    run = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (5) @(negedge clk);

    cur_req = "R3 largest low count";
    xfer(15, 255, 0, 15, 15, 1, 0);
    chk("R3 low length max", meas_low, 4096);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule